// File: doc/BRIEF.md
# Hysteresis Thermostat Controller

This block switches a heater or a cooler on and off. It compares an unsigned current temperature with a user setpoint. Each mode runs its own small loop. While the loop is active, the output is on until the setpoint is reached. The loop then pauses with the output off. It becomes active again only once the temperature has drifted away from the setpoint by a programmable hysteresis gap. This gap prevents rapid toggling when the temperature sits near the setpoint.

Three single-cycle strobes drive the block: a heating request, a cooling request and an exit. Exit always wins. A request for the other mode while one mode is running makes the controller leave through the exit state first. It then enters the requested mode. The current state is reported as a 3-bit code so that a display or a supervising processor can follow the controller.

Top module: `thermostat_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the state code is 0 (idle) and both enables are low until a request arrives.
- R2: A heating request in idle enters active heating (code 1) if temperature < setpoint, otherwise heating pause (code 2). The heater enable is high exactly while the state is code 1.
- R3: In active heating, a clock edge that samples temperature >= setpoint moves the state to heating pause, and the heater turns off in the same cycle.
- R4: Heating pause returns to active heating at the edge that samples temperature <= setpoint − hysteresis. The subtraction saturates at 0.
- R5: A cooling request in idle enters active cooling (code 3) if temperature > setpoint, otherwise cooling pause (code 4). The cooler enable is high exactly while the state is code 3. Active cooling moves to cooling pause once temperature <= setpoint.
- R6: Cooling pause returns to active cooling at the edge that samples temperature >= setpoint + hysteresis. The addition saturates at the largest temperature code.
- R7: An exit strobe in any state other than idle moves the state to exit (code 5) at the next edge, with both enables low. Exit then falls to idle at the following edge. An exit strobe in idle changes nothing.
- R8: A request for the other mode while a mode runs moves the state to exit for one cycle with both enables low, then into the requested mode's entry state as in R2/R5. If exit arrives together with such a request, the request is dropped and the state ends in idle.
- R9: The heater and cooler enables are never high in the same cycle.
- R10: A request for the mode already running is ignored. Heating and cooling requested together from idle selects heating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_i | input | 8 | Current temperature, unsigned |
| setpt_i | input | 8 | Setpoint, unsigned |
| hyst_i | input | 8 | Hysteresis gap before re-activation |
| heat_req_i | input | 1 | Heating mode request strobe |
| cool_req_i | input | 1 | Cooling mode request strobe |
| exit_req_i | input | 1 | Exit strobe |
| heat_en_o | output | 1 | Heater enable |
| cool_en_o | output | 1 | Cooler enable |
| state_o | output | 3 | State code (0 idle, 1/2 heat active/pause, 3/4 cool active/pause, 5 exit) |

## Verification
The hold and transition assertions assume that temperature, setpoint and hysteresis are stable, known values at each sampling edge. They also assume the hysteresis is no wider than the temperature. Each transition property is conditioned on the absence of exit and cross-mode strobes in that cycle, because those strobes legally override the temperature-driven moves. The stimulus changes every input only on the falling clock edge and uses 8-bit values throughout. It also holds temperatures at chosen points on either side of each threshold, so that every threshold edge is sampled cleanly.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_HEAT_ON   = 3'd1,
    ST_HEAT_HOLD = 3'd2,
    ST_COOL_ON   = 3'd3,
    ST_COOL_HOLD = 3'd4,
    ST_LEAVE     = 3'd5
  } thermo_state_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_HEAT = 2'd1,
    PEND_COOL = 2'd2
  } thermo_pend_e;

  function automatic logic in_heat(input thermo_state_e s);
    return (s == ST_HEAT_ON) || (s == ST_HEAT_HOLD);
  endfunction

  function automatic logic in_cool(input thermo_state_e s);
    return (s == ST_COOL_ON) || (s == ST_COOL_HOLD);
  endfunction

endpackage

// File: rtl/thermo_band.sv
// Threshold evaluation for one control loop: "reached" ends an active phase,
// "resume" ends a pause once the temperature leaves the hysteresis gap.
module thermo_band #(
  parameter int TW   = 8,
  parameter int HW   = 8,
  parameter bit COOL = 1'b0
) (
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] setpt_i,
  input  logic [HW-1:0] hyst_i,
  output logic          reached_o,
  output logic          resume_o
);

  localparam int            EW   = TW + 1;
  localparam logic [TW-1:0] TMAX = '1;

  // setpoint + gap, clamped to the top temperature code
  function automatic logic [TW-1:0] sat_up(input logic [TW-1:0] b,
                                           input logic [HW-1:0] h);
    logic [EW-1:0] s;
    s = {1'b0, b} + EW'(h);
    return s[TW] ? TMAX : s[TW-1:0];
  endfunction

  // setpoint - gap, clamped to zero
  function automatic logic [TW-1:0] sat_dn(input logic [TW-1:0] b,
                                           input logic [HW-1:0] h);
    logic [EW-1:0] d;
    d = {1'b0, b} - EW'(h);
    return d[TW] ? '0 : d[TW-1:0];
  endfunction

  logic [TW-1:0] thresh;

  if (COOL) begin : g_cool
    assign thresh    = sat_up(setpt_i, hyst_i);
    assign reached_o = (temp_i <= setpt_i);
    assign resume_o  = (temp_i >= thresh);
  end else begin : g_heat
    assign thresh    = sat_dn(setpt_i, hyst_i);
    assign reached_o = (temp_i >= setpt_i);
    assign resume_o  = (temp_i <= thresh);
  end

endmodule

// File: rtl/thermo_seq.sv
// Mode sequencer: idle, two active/pause loops, and a shared exit state.
module thermo_seq
  import thermo_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          heat_req_i,
  input  logic          cool_req_i,
  input  logic          exit_req_i,
  input  logic          heat_reached_i,
  input  logic          heat_resume_i,
  input  logic          cool_reached_i,
  input  logic          cool_resume_i,
  output thermo_state_e state_o
);

  thermo_state_e state_q, state_d;
  thermo_pend_e  pend_q, pend_d;
  thermo_state_e heat_entry, cool_entry;

  assign heat_entry = heat_reached_i ? ST_HEAT_HOLD : ST_HEAT_ON;
  assign cool_entry = cool_reached_i ? ST_COOL_HOLD : ST_COOL_ON;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    if (exit_req_i) begin
      pend_d = PEND_NONE;
      if (state_q != ST_IDLE) state_d = ST_LEAVE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (heat_req_i)      state_d = heat_entry;
          else if (cool_req_i) state_d = cool_entry;
        end
        ST_HEAT_ON: begin
          if (cool_req_i) begin
            state_d = ST_LEAVE;
            pend_d  = PEND_COOL;
          end else if (heat_reached_i) state_d = ST_HEAT_HOLD;
        end
        ST_HEAT_HOLD: begin
          if (cool_req_i) begin
            state_d = ST_LEAVE;
            pend_d  = PEND_COOL;
          end else if (heat_resume_i) state_d = ST_HEAT_ON;
        end
        ST_COOL_ON: begin
          if (heat_req_i) begin
            state_d = ST_LEAVE;
            pend_d  = PEND_HEAT;
          end else if (cool_reached_i) state_d = ST_COOL_HOLD;
        end
        ST_COOL_HOLD: begin
          if (heat_req_i) begin
            state_d = ST_LEAVE;
            pend_d  = PEND_HEAT;
          end else if (cool_resume_i) state_d = ST_COOL_ON;
        end
        ST_LEAVE: begin
          pend_d = PEND_NONE;
          case (pend_q)
            PEND_HEAT: state_d = heat_entry;
            PEND_COOL: state_d = cool_entry;
            default:   state_d = ST_IDLE;
          endcase
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= PEND_NONE;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o = state_q;

  // exit strobe wins over any move
  assert_exit_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req_i && state_q != ST_IDLE) |=> (state_q == ST_LEAVE));

  // exit state lasts one cycle unless exit is strobed again
  assert_leave_brief_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEAVE && !exit_req_i) |=> (state_q != ST_LEAVE));

  // no direct hop between the two loops
  assert_no_swap_heat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_heat(state_q) |=> !in_cool(state_q));
  assert_no_swap_cool_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_cool(state_q) |=> !in_heat(state_q));

  // active heating pauses when the setpoint is reached
  assert_heat_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HEAT_ON && heat_reached_i && !exit_req_i && !cool_req_i)
    |=> (state_q == ST_HEAT_HOLD));

  // heating pause holds inside the gap
  assert_heat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HEAT_HOLD && !heat_resume_i && !exit_req_i && !cool_req_i)
    |=> (state_q == ST_HEAT_HOLD));

  // cooling pause holds inside the gap
  assert_cool_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COOL_HOLD && !cool_resume_i && !exit_req_i && !heat_req_i)
    |=> (state_q == ST_COOL_HOLD));

  // exit in idle is a no-op
  assert_idle_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && exit_req_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/thermostat_ctrl.sv
module thermostat_ctrl
  import thermo_pkg::*;
#(
  parameter int TW = 8,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] setpt_i,
  input  logic [HW-1:0] hyst_i,
  input  logic          heat_req_i,
  input  logic          cool_req_i,
  input  logic          exit_req_i,
  output logic          heat_en_o,
  output logic          cool_en_o,
  output logic [2:0]    state_o
);

  localparam int NLEG = 2;  // leg 0 heats, leg 1 cools

  logic [NLEG-1:0] reached, resume;
  thermo_state_e   state;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    thermo_band #(
      .TW  (TW),
      .HW  (HW),
      .COOL(g == 1)
    ) u_band (
      .temp_i   (temp_i),
      .setpt_i  (setpt_i),
      .hyst_i   (hyst_i),
      .reached_o(reached[g]),
      .resume_o (resume[g])
    );
  end

  thermo_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .heat_req_i    (heat_req_i),
    .cool_req_i    (cool_req_i),
    .exit_req_i    (exit_req_i),
    .heat_reached_i(reached[0]),
    .heat_resume_i (resume[0]),
    .cool_reached_i(reached[1]),
    .cool_resume_i (resume[1]),
    .state_o       (state)
  );

  assign heat_en_o = (state == ST_HEAT_ON);
  assign cool_en_o = (state == ST_COOL_ON);
  assign state_o   = state;

  assert_one_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(heat_en_o && cool_en_o));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (state_o == 3'd0 && !heat_en_o && !cool_en_o));

endmodule

// File: tb/tb_thermostat_ctrl.sv
module tb_thermostat_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] temp = 8'd0, setpt = 8'd0, hyst = 8'd0;
  logic       heat_req = 1'b0, cool_req = 1'b0, exit_req = 1'b0;
  logic       heat_en, cool_en;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  thermostat_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .temp_i    (temp),
    .setpt_i   (setpt),
    .hyst_i    (hyst),
    .heat_req_i(heat_req),
    .cool_req_i(cool_req),
    .exit_req_i(exit_req),
    .heat_en_o (heat_en),
    .cool_en_o (cool_en),
    .state_o   (state)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // enables follow the state code (R2, R5) and are never both high (R9)
  task automatic expect_st(input string tag, input int st);
    chk({tag, " state"}, int'(state), st);
    chk({tag, " heat_en R2"}, int'(heat_en), int'(st == 1));
    chk({tag, " cool_en R5"}, int'(cool_en), int'(st == 3));
    chk("R9 exclusive", int'(heat_en & cool_en), 0);
  endtask

  task automatic pulse(input bit h, input bit c, input bit e);
    heat_req = h; cool_req = c; exit_req = e;
    step();
    heat_req = 1'b0; cool_req = 1'b0; exit_req = 1'b0;
  endtask

  task automatic leave_to_idle();
    pulse(0, 0, 1);
    expect_st("R7 exit", 5);
    step();
    expect_st("R7 back to idle", 0);
  endtask

  task automatic t_reset();
    repeat (3) step();
    expect_st("R1 in reset", 0);
    rst_n = 1'b1;
    step(); step();
    expect_st("R1 after release", 0);
  endtask

  task automatic t_heat_loop();
    setpt = 8'd100; hyst = 8'd5; temp = 8'd90;
    pulse(1, 0, 0);
    expect_st("R2 heat entry active", 1);
    temp = 8'd99;  step(); expect_st("R3 below setpoint", 1);
    temp = 8'd100; step(); expect_st("R3 reach pause", 2);
    temp = 8'd96;  step(); expect_st("R4 inside gap", 2);
    temp = 8'd95;  step(); expect_st("R4 resume", 1);
    pulse(1, 0, 0);
    expect_st("R10 same mode ignored", 1);
    leave_to_idle();
  endtask

  task automatic t_heat_entry_hold();
    setpt = 8'd100; hyst = 8'd5; temp = 8'd120;
    pulse(1, 0, 0);
    expect_st("R2 heat entry pause", 2);
    leave_to_idle();
  endtask

  task automatic t_heat_sat();
    setpt = 8'd3; hyst = 8'd10; temp = 8'd5;
    pulse(1, 0, 0);
    expect_st("R4 sat entry", 2);
    temp = 8'd1; step(); expect_st("R4 sat hold", 2);
    temp = 8'd0; step(); expect_st("R4 sat resume at 0", 1);
    leave_to_idle();
  endtask

  task automatic t_cool_loop();
    setpt = 8'd100; hyst = 8'd5; temp = 8'd110;
    pulse(0, 1, 0);
    expect_st("R5 cool entry active", 3);
    temp = 8'd101; step(); expect_st("R5 above setpoint", 3);
    temp = 8'd100; step(); expect_st("R5 reach pause", 4);
    temp = 8'd104; step(); expect_st("R6 inside gap", 4);
    temp = 8'd105; step(); expect_st("R6 resume", 3);
    pulse(0, 1, 0);
    expect_st("R10 same cool ignored", 3);
    leave_to_idle();
  endtask

  task automatic t_cool_sat();
    setpt = 8'd250; hyst = 8'd10; temp = 8'd240;
    pulse(0, 1, 0);
    expect_st("R5 cool entry pause", 4);
    temp = 8'd254; step(); expect_st("R6 sat hold", 4);
    temp = 8'd255; step(); expect_st("R6 sat resume at 255", 3);
    temp = 8'd250; step(); expect_st("R5 pause at setpoint", 4);
    leave_to_idle();
  endtask

  task automatic t_swap();
    setpt = 8'd100; hyst = 8'd5; temp = 8'd90;
    pulse(0, 1, 0);
    expect_st("R5 cool entry pause low temp", 4);
    pulse(1, 0, 0);
    expect_st("R8 swap passes exit", 5);
    step();
    expect_st("R8 heat after exit", 1);
    pulse(0, 1, 0);
    expect_st("R8 swap back exit", 5);
    step();
    expect_st("R8 cool after exit", 4);
    pulse(1, 0, 1);
    expect_st("R8 exit beats request", 5);
    step();
    expect_st("R8 request dropped", 0);
  endtask

  task automatic t_idle_cases();
    pulse(0, 0, 1);
    expect_st("R7 exit in idle", 0);
    step();
    expect_st("R7 idle stays", 0);
    temp = 8'd90; setpt = 8'd100;
    pulse(1, 1, 0);
    expect_st("R10 heat wins", 1);
    pulse(0, 0, 1);
    expect_st("R7 exit from active", 5);
    pulse(0, 0, 1);
    expect_st("R7 exit again holds exit", 5);
    step();
    expect_st("R7 idle after exit", 0);
  endtask

  initial begin
    t_reset();
    t_heat_loop();
    t_heat_entry_hold();
    t_heat_sat();
    t_cool_loop();
    t_cool_sat();
    t_swap();
    t_idle_cases();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule